// File: doc/BRIEF.md
# Width-Adapting External Memory Controller

This block sits between a 32-bit internal request port and an asynchronous external memory bus. Each request carries a 24-bit word address, a read/write flag, a fetch flag and write data. The block decodes the address into one of two general memory strobe groups, a single I/O strobe, or an on-chip region that needs no external cycle. It then turns the request into one or more external cycles. The number of cycles depends on the physical width of the addressed memory and on the logical width of the data stored there. Each of these two widths is configured on its own for every memory group.

Each memory group drives four active-low lines. Depending on the physical width, two of these lines act as byte enables or as the lowest byte-address bits. Each external cycle lasts at least one clock and is stretched while the ready input is low. I/O cycles add a fixed extra clock before ready is sampled. Multi-cycle accesses run from the lower address upward, and the pieces are packed little-endian into one response. Instruction fetches use a separate program-width input that selects one 32-bit read or two 16-bit halves.

Top module: `ext_mem_ctrl`

## Requirements
- R1: Word address bit pattern selects the target: below 800000h or 880000h–8FFFFFh uses memory group 0; 900000h and above uses memory group 1; 810000h–82FFFFh uses the I/O strobe; every other address (internal RAM 87FE00h–87FFFFh, peripheral registers 808000h–8097FFh, reserved space) produces no external cycle, and the response still arrives with `rsp_err_o` low. At most one target is active in any clock.
- R2: `ext_rd_o` is high during read cycles and when idle, and low only during write cycles.
- R3: Config field encoding per group is `cfg = {data_w[1:0], phys_w[1:0]}` with 00 = 8 bit, 01 = 16 bit, 10 or 11 = 32 bit. The byte address of a location is word address × data bytes. With 32-bit physical width, all four lines are active-low byte enables for data lanes 0..3; `ext_addr_o` = byte address / 4; only the addressed lanes are enabled; write data is placed on those lanes.
- R4: With 16-bit physical width, line 3 carries byte-address bit 1, lines 0 and 1 enable data byte lanes 0 and 1, and line 2 stays high.
- R5: With 8-bit physical width, lines 3 and 2 carry byte-address bits 1 and 0, line 0 is low as the only enable, line 1 stays high, and data uses lane 0.
- R6: When data width exceeds physical width, data bytes / physical bytes external cycles run at rising byte addresses, and the pieces are packed little-endian (first cycle in the lowest bits). A narrower read is zero-extended in `rsp_rdata_o`.
- R7: An external cycle completes on the first clock edge at which `ext_rdy_i` is high. While it is low, address and lines hold still.
- R8: An I/O cycle is always a single 32-bit cycle whose strobe stays low for at least one fixed clock more than a memory cycle (two clocks with ready high).
- R9: A fetch ignores the group's data width. With `prog_w16_i` low it performs one 32-bit read with all four enables. With it high it performs two 16-bit reads (line 3 = 0, then 1), assembled low half first.
- R10: A fetch aimed at a group configured for 8-bit physical width causes no external cycle and responds with `rsp_err_o` high.
- R11: After reset and between requests, all lines and `io_strb_no` are high and `req_ready_o` is high. `req_ready_o` is low while a request is in progress. `rsp_valid_o` is a one-clock pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted this clock |
| req_addr_i | input | 24 | Word address |
| req_we_i | input | 1 | 1 = write |
| req_fetch_i | input | 1 | 1 = instruction fetch (read) |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| rsp_err_o | output | 1 | Rejected fetch |
| cfg0_i | input | 4 | Group 0 widths {data, physical} |
| cfg1_i | input | 4 | Group 1 widths {data, physical} |
| prog_w16_i | input | 1 | Program memory is 16 bits wide |
| ext_addr_o | output | 24 | External address |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data |
| ext_rd_o | output | 1 | High = read, low = write |
| grp0_ln_o | output | 4 | Group 0 lines, active low |
| grp1_ln_o | output | 4 | Group 1 lines, active low |
| io_strb_no | output | 1 | I/O strobe, active low |
| ext_rdy_i | input | 1 | External ready |

## Verification
A wrong beat counter or width decode shows at the ports within the same request, as an extra or missing active clock on the group lines or as a misplaced address bit on lines 2 and 3. Wrong lane offsets show as a read byte landing in the wrong position of `rsp_rdata_o` one clock after the last beat, or as write data on the wrong lanes during the beat itself. A stuck state machine shows at once as `req_ready_o` staying low or a missing response pulse. A wrong I/O wait count shows as a strobe that is one clock too short.

// File: rtl/ext_mem_pkg.sv
package ext_mem_pkg;
  typedef enum logic [1:0] {RG_NONE, RG_MEM0, RG_MEM1, RG_IO} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RESP} state_e;

  // width field -> log2 of byte count; 11 treated as 32 bit
  function automatic logic [1:0] width_log(input logic [1:0] f);
    return (f == 2'b11) ? 2'd2 : f;
  endfunction
endpackage

// File: rtl/ext_mem_decode.sv
module ext_mem_decode
  import ext_mem_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  logic [7:0] top;
  assign top = addr_i[ADDR_W-1 -: 8];

  always_comb begin
    if (top < 8'h80)                      region_o = RG_MEM0;
    else if (top >= 8'h90)                region_o = RG_MEM1;
    else if (top[7:3] == 5'b10001)        region_o = RG_MEM0;
    else if (top == 8'h81 || top == 8'h82) region_o = RG_IO;
    else                                  region_o = RG_NONE;
  end
endmodule

// File: rtl/ext_mem_beat.sv
module ext_mem_beat #(
  parameter int BA_W   = 26,
  parameter int DATA_W = 32
) (
  input  logic [BA_W-1:0]   base_i,
  input  logic [1:0]        dl_i,
  input  logic [1:0]        pl_i,
  input  logic [1:0]        k_i,
  output logic [BA_W-1:0]   baddr_o,
  output logic [3:0]        mask_o,
  output logic [1:0]        off_o,
  output logic [DATA_W-1:0] nmask_o
);
  logic [1:0] nlog;
  logic [3:0] span;

  assign nlog    = (dl_i < pl_i) ? dl_i : pl_i;
  assign baddr_o = base_i + (BA_W'(k_i) << pl_i);

  always_comb begin
    case (pl_i)
      2'd0:    off_o = 2'd0;
      2'd1:    off_o = {1'b0, baddr_o[0]};
      default: off_o = baddr_o[1:0];
    endcase
    case (nlog)
      2'd0:    begin span = 4'b0001; nmask_o = DATA_W'(32'h0000_00FF); end
      2'd1:    begin span = 4'b0011; nmask_o = DATA_W'(32'h0000_FFFF); end
      default: begin span = 4'b1111; nmask_o = '1; end
    endcase
  end

  assign mask_o = span << off_o;
endmodule

// File: rtl/ext_mem_pins.sv
module ext_mem_pins (
  input  logic       active_i,
  input  logic [1:0] pl_i,
  input  logic [1:0] blo_i,
  input  logic [3:0] mask_i,
  output logic [3:0] ln_o
);
  always_comb begin
    if (!active_i) ln_o = 4'hF;
    else begin
      case (pl_i)
        2'd0:    ln_o = {blo_i[1], blo_i[0], 1'b1, 1'b0};
        2'd1:    ln_o = {blo_i[1], 1'b1, ~mask_i[1], ~mask_i[0]};
        default: ln_o = ~mask_i;
      endcase
    end
  end
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import ext_mem_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int IO_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic              req_fetch_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic [3:0]        cfg0_i,
  input  logic [3:0]        cfg1_i,
  input  logic              prog_w16_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              ext_rd_o,
  output logic [3:0]        grp0_ln_o,
  output logic [3:0]        grp1_ln_o,
  output logic              io_strb_no,
  input  logic              ext_rdy_i
);
  localparam int BA_W  = ADDR_W + 2;
  localparam int IOC_W = (IO_WAIT < 1) ? 1 : $clog2(IO_WAIT + 1);
  localparam int SH_W  = $clog2(DATA_W) + 1;

  state_e             state;
  region_e            a_region, r_region;
  logic [ADDR_W-1:0]  r_addr;
  logic               r_we, r_err;
  logic [DATA_W-1:0]  r_wdata, r_acc;
  logic [1:0]         r_dl, r_pl, r_last, r_k;
  logic [IOC_W-1:0]   r_iocnt;

  logic [3:0]         a_cfg;
  logic [1:0]         a_dl, a_pl, a_last;
  logic               a_err, accept, xfer, beat_done;

  logic [BA_W-1:0]    base, baddr;
  logic [3:0]         mask;
  logic [1:0]         off;
  logic [DATA_W-1:0]  nmask, piece, wchunk;
  logic [SH_W-1:0]    sh_k, sh_off;

  ext_mem_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(req_addr_i), .region_o(a_region));

  // request classification at accept
  always_comb begin
    a_cfg = (a_region == RG_MEM1) ? cfg1_i : cfg0_i;
    a_err = 1'b0;
    if (a_region == RG_IO) begin
      a_dl = 2'd2; a_pl = 2'd2;
    end else if (req_fetch_i) begin
      a_dl  = 2'd2;
      a_pl  = prog_w16_i ? 2'd1 : 2'd2;
      a_err = (a_region != RG_NONE) && (width_log(a_cfg[1:0]) == 2'd0);
    end else begin
      a_dl = width_log(a_cfg[3:2]);
      a_pl = width_log(a_cfg[1:0]);
    end
    if (a_dl > a_pl) a_last = (a_dl - a_pl == 2'd2) ? 2'd3 : 2'd1;
    else             a_last = 2'd0;
  end

  assign accept    = (state == ST_IDLE) && req_valid_i;
  assign xfer      = (state == ST_XFER);
  assign beat_done = xfer && ext_rdy_i && (r_iocnt == '0);

  assign base = BA_W'(r_addr) << r_dl;

  ext_mem_beat #(.BA_W(BA_W), .DATA_W(DATA_W)) u_beat (
    .base_i(base), .dl_i(r_dl), .pl_i(r_pl), .k_i(r_k),
    .baddr_o(baddr), .mask_o(mask), .off_o(off), .nmask_o(nmask)
  );

  assign sh_k   = SH_W'(r_k) << ({1'b0, r_pl} + 3'd3);
  assign sh_off = SH_W'(off) << 3;
  assign piece  = (ext_rdata_i >> sh_off) & nmask;
  assign wchunk = (r_wdata >> sh_k) & nmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      r_region <= RG_NONE;
      r_addr   <= '0;
      r_we     <= 1'b0;
      r_err    <= 1'b0;
      r_wdata  <= '0;
      r_acc    <= '0;
      r_dl     <= '0;
      r_pl     <= '0;
      r_last   <= '0;
      r_k      <= '0;
      r_iocnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_region <= a_region;
          r_addr   <= req_addr_i;
          r_we     <= req_we_i && !req_fetch_i;
          r_wdata  <= req_wdata_i;
          r_dl     <= a_dl;
          r_pl     <= a_pl;
          r_last   <= a_last;
          r_k      <= '0;
          r_acc    <= '0;
          r_err    <= a_err;
          r_iocnt  <= (a_region == RG_IO) ? IOC_W'(IO_WAIT) : '0;
          state    <= (a_region == RG_NONE || a_err) ? ST_RESP : ST_XFER;
        end
        ST_XFER: begin
          if (r_iocnt != '0) r_iocnt <= r_iocnt - 1'b1;
          if (beat_done) begin
            if (!r_we) r_acc <= r_acc | (piece << sh_k);
            if (r_k == r_last) state <= ST_RESP;
            else               r_k   <= r_k + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign rsp_valid_o = (state == ST_RESP);
  assign rsp_rdata_o = r_acc;
  assign rsp_err_o   = r_err;

  assign ext_addr_o  = xfer ? baddr[BA_W-1:2] : '0;
  assign ext_rd_o    = !(xfer && r_we);
  assign ext_wdata_o = (xfer && r_we) ? (wchunk << sh_off) : '0;
  assign io_strb_no  = !(xfer && r_region == RG_IO);

  logic [3:0] grp_ln [2];
  for (genvar g = 0; g < 2; g++) begin : g_grp
    ext_mem_pins u_pins (
      .active_i(xfer && (r_region == ((g == 0) ? RG_MEM0 : RG_MEM1))),
      .pl_i(r_pl), .blo_i(baddr[1:0]), .mask_i(mask), .ln_o(grp_ln[g])
    );
  end
  assign grp0_ln_o = grp_ln[0];
  assign grp1_ln_o = grp_ln[1];

  p_one_target_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~&grp0_ln_o, ~&grp1_ln_o, ~io_strb_no}));

  p_write_in_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rd_o |-> (!(&grp0_ln_o) || !(&grp1_ln_o) || !io_strb_no));

  p_beat_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |-> (r_k <= r_last));

  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !ext_rdy_i) |=> ($stable(ext_addr_o) && $stable(grp0_ln_o) &&
                              $stable(grp1_ln_o) && $stable(io_strb_no)));

  p_io_min_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_strb_no) |=> !io_strb_no);

  p_err_no_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> ($past(state) == ST_IDLE));

  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
endmodule

// File: tb/ext_mem_ctrl_bench.sv
module ext_mem_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0, req_fetch_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic [3:0]  cfg0_i = 4'b1010, cfg1_i = 4'b1010;
  logic        prog_w16_i = 1'b0;
  logic [23:0] ext_addr_o;
  logic [31:0] ext_wdata_o, ext_rdata_i;
  logic        ext_rd_o, io_strb_no;
  logic [3:0]  grp0_ln_o, grp1_ln_o;
  logic        ext_rdy_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  int tb_pw = 32;

  always #10 clk_i = ~clk_i;

  ext_mem_ctrl u_ext_mem_ctrl (.*);

  function automatic logic [7:0] mb(input logic [25:0] x);
    logic [7:0] t;
    t = x[7:0] * 8'd13;
    return t ^ x[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_word(input logic [25:0] b, input int n);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = mb(b + 26'(i));
    return w;
  endfunction

  logic       bus_act;
  logic [3:0] act_ln;
  assign bus_act = !(&grp0_ln_o) || !(&grp1_ln_o) || !io_strb_no;
  assign act_ln  = (&grp0_ln_o) ? grp1_ln_o : grp0_ln_o;

  // external memory model
  always_comb begin
    logic [25:0] ba;
    ba = {ext_addr_o, 2'b00};
    if (tb_pw == 8) begin
      ba[1:0] = act_ln[3:2];
      ext_rdata_i = {24'h0, mb(ba)};
    end else if (tb_pw == 16) begin
      ba[1] = act_ln[3];
      ext_rdata_i = {16'h0, mb(ba + 26'd1), mb(ba)};
    end else begin
      ext_rdata_i = exp_word(ba, 4);
    end
  end

  // bus monitor
  logic [23:0] s_addr [64];
  logic [3:0]  s_ln   [64];
  logic [31:0] s_wd   [64];
  logic [1:0]  s_grp  [64];
  logic        s_rd   [64];
  int          s_tot = 0;
  always @(negedge clk_i) begin
    if (bus_act) begin
      s_addr[s_tot[5:0]] <= ext_addr_o;
      s_ln[s_tot[5:0]]   <= act_ln;
      s_wd[s_tot[5:0]]   <= ext_wdata_o;
      s_rd[s_tot[5:0]]   <= ext_rd_o;
      s_grp[s_tot[5:0]]  <= !io_strb_no ? 2'd2 : (!(&grp1_ln_o) ? 2'd1 : 2'd0);
      s_tot <= s_tot + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int          g_base, g_nact;
  logic [31:0] g_rdata;
  logic        g_err, g_done;

  function automatic int ix(input int i);
    return (g_base + i) % 64;
  endfunction

  task automatic do_req(input logic [23:0] a, input logic we, input logic fe,
                        input logic [31:0] wd, input int hold);
    int  act;
    bit  busy_rdy;
    @(negedge clk_i);
    req_addr_i = a; req_we_i = we; req_fetch_i = fe; req_wdata_i = wd;
    req_valid_i = 1'b1;
    ext_rdy_i = (hold == 0);
    g_base = s_tot;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    act = 0; busy_rdy = 0; g_done = 0;
    for (int i = 0; i < 60 && !g_done; i++) begin
      if (rsp_valid_o) begin
        g_rdata = rsp_rdata_o; g_err = rsp_err_o; g_done = 1;
      end else begin
        if (req_ready_o) busy_rdy = 1;
        if (bus_act) begin
          act++;
          if (act >= hold) ext_rdy_i = 1'b1;
        end
        @(negedge clk_i);
      end
    end
    ext_rdy_i = 1'b1;
    g_nact = s_tot - g_base;
    chk("R11 response pulse seen", 32'(g_done), 32'd1);
    chk("R11 ready low while busy", 32'(busy_rdy), 32'd0);
    @(negedge clk_i);
    chk("R11 response one clock", 32'(rsp_valid_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 reset ready", 32'(req_ready_o), 32'd1);
    chk("R11 reset no rsp", 32'(rsp_valid_o), 32'd0);
    chk("R11 reset lines", {24'h0, grp1_ln_o, grp0_ln_o}, 32'h0000_00FF);
    chk("R11 reset io strobe", 32'(io_strb_no), 32'd1);
    chk("R2 idle read level", 32'(ext_rd_o), 32'd1);
  endtask

  task automatic t_p32_byte_read;
    cfg0_i = 4'b0010; tb_pw = 32;
    do_req(24'h000005, 1'b0, 1'b0, '0, 0);
    chk("R3 beats", g_nact, 1);
    chk("R3 addr", 32'(s_addr[ix(0)]), 32'h1);
    chk("R3 lane1 enable", 32'(s_ln[ix(0)]), 32'hD);
    chk("R1 group0", 32'(s_grp[ix(0)]), 32'd0);
    chk("R2 read level", 32'(s_rd[ix(0)]), 32'd1);
    chk("R6 zero-extended byte", g_rdata, {24'h0, mb(26'd5)});
  endtask

  task automatic t_p32_half_write;
    cfg0_i = 4'b0110; tb_pw = 32;
    do_req(24'h000003, 1'b1, 1'b0, 32'h0000_BEEF, 0);
    chk("R3 beats", g_nact, 1);
    chk("R3 upper lanes", 32'(s_ln[ix(0)]), 32'h3);
    chk("R3 wdata lanes", {16'h0, s_wd[ix(0)][31:16]}, 32'hBEEF);
    chk("R2 write level", 32'(s_rd[ix(0)]), 32'd0);
  endtask

  task automatic t_p16_word_read;
    logic [25:0] b;
    cfg1_i = 4'b1001; tb_pw = 16;
    b = {24'h900010, 2'b00};
    do_req(24'h900010, 1'b0, 1'b0, '0, 0);
    chk("R6 two beats", g_nact, 2);
    chk("R1 group1", 32'(s_grp[ix(0)]), 32'd1);
    chk("R4 addr", 32'(s_addr[ix(1)]), 32'h900010);
    chk("R4 beat0 lines", 32'(s_ln[ix(0)]), 32'h4);
    chk("R4 beat1 lines", 32'(s_ln[ix(1)]), 32'hC);
    chk("R6 packed read", g_rdata, exp_word(b, 4));
  endtask

  task automatic t_p16_byte_write;
    cfg1_i = 4'b0001; tb_pw = 16;
    do_req(24'h900005, 1'b1, 1'b0, 32'h0000_00AB, 0);
    chk("R4 beats", g_nact, 1);
    chk("R4 addr", 32'(s_addr[ix(0)]), 32'h240001);
    chk("R4 lane1 lines", 32'(s_ln[ix(0)]), 32'h5);
    chk("R4 wdata lane1", 32'(s_wd[ix(0)][15:8]), 32'hAB);
  endtask

  task automatic t_p8_word_write;
    cfg0_i = 4'b1000; tb_pw = 8;
    do_req(24'h000100, 1'b1, 1'b0, 32'h4433_2211, 0);
    chk("R6 four beats", g_nact, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 addr", 32'(s_addr[ix(k)]), 32'h100);
      chk("R5 lines", 32'(s_ln[ix(k)]), 32'({k[1:0], 2'b10}));
      chk("R6 byte order", 32'(s_wd[ix(k)][7:0]), 32'(8'h11 * (k + 1)));
    end
  endtask

  task automatic t_p8_half_read;
    cfg0_i = 4'b0100; tb_pw = 8;
    do_req(24'h000003, 1'b0, 1'b0, '0, 0);
    chk("R6 two beats", g_nact, 2);
    chk("R5 beat0 lines", 32'(s_ln[ix(0)]), 32'hA);
    chk("R5 beat1 lines", 32'(s_ln[ix(1)]), 32'hE);
    chk("R6 packed half", g_rdata, {16'h0, mb(26'd7), mb(26'd6)});
  endtask

  task automatic t_io_read;
    tb_pw = 32;
    do_req(24'h810004, 1'b0, 1'b0, '0, 0);
    chk("R8 io strobe clocks", g_nact, 2);
    chk("R8 io target", 32'(s_grp[ix(0)]), 32'd2);
    chk("R8 io addr", 32'(s_addr[ix(0)]), 32'h810004);
    chk("R8 io data", g_rdata, exp_word({24'h810004, 2'b00}, 4));
  endtask

  task automatic t_wait_states;
    cfg0_i = 4'b1010; tb_pw = 32;
    do_req(24'h880000, 1'b0, 1'b0, '0, 3);
    chk("R7 stretched clocks", g_nact, 3);
    chk("R7 addr held", 32'(s_addr[ix(2)]), 32'h880000);
    chk("R1 upper group0 range", 32'(s_grp[ix(0)]), 32'd0);
    chk("R7 data after wait", g_rdata, exp_word({24'h880000, 2'b00}, 4));
  endtask

  task automatic t_fetch16;
    cfg0_i = 4'b0010; prog_w16_i = 1'b1; tb_pw = 16;
    do_req(24'h000040, 1'b0, 1'b1, '0, 0);
    chk("R9 two halves", g_nact, 2);
    chk("R9 half0 lines", 32'(s_ln[ix(0)]), 32'h4);
    chk("R9 half1 lines", 32'(s_ln[ix(1)]), 32'hC);
    chk("R9 assembled", g_rdata, exp_word(26'h100, 4));
  endtask

  task automatic t_fetch32;
    prog_w16_i = 1'b0; tb_pw = 32;
    do_req(24'h000040, 1'b0, 1'b1, '0, 0);
    chk("R9 one word", g_nact, 1);
    chk("R9 all enables", 32'(s_ln[ix(0)]), 32'h0);
    chk("R9 word", g_rdata, exp_word(26'h100, 4));
  endtask

  task automatic t_fetch8_err;
    cfg0_i = 4'b1000;
    do_req(24'h000010, 1'b0, 1'b1, '0, 0);
    chk("R10 no cycle", g_nact, 0);
    chk("R10 err flag", 32'(g_err), 32'd1);
  endtask

  task automatic t_internal;
    cfg0_i = 4'b1010;
    do_req(24'h87FE10, 1'b0, 1'b0, '0, 0);
    chk("R1 internal ram no cycle", g_nact, 0);
    chk("R1 internal no err", 32'(g_err), 32'd0);
    do_req(24'h808000, 1'b1, 1'b0, 32'h1234_5678, 0);
    chk("R1 periph regs no cycle", g_nact, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_p32_byte_read;
    t_p32_half_write;
    t_p16_word_read;
    t_p16_byte_write;
    t_p8_word_write;
    t_p8_half_read;
    t_io_read;
    t_wait_states;
    t_fetch16;
    t_fetch32;
    t_fetch8_err;
    t_internal;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule